// File: doc/BRIEF.md
# Supply-Qualified Start-Up Sequencer

This block decides when a pair of high-voltage scan clock drivers may run. It watches a digitised code of the positive high supply and an enable input. It holds the scan clock controller in one of three modes: lockout, where every driver output floats; forced-low, where every output is tied to the low rail; or run.

The supply is judged good by an undervoltage detector with hysteresis. The block leaves forced-low only after a programmable number of clock cycles has passed. That count stands in for an external timing capacitor. The delay is started by whichever comes last: the enable rising, or the supply becoming good while enable is already high.

Top module: `rail_startup_seq`

## Requirements
- R1: During and right after reset, `scan_mode` is 0 (lockout). The mode encoding is 0 = lockout, 1 = forced-low, 2 = run; the value 3 never appears.
- R2: With the supply flagged bad, a `supply_code` at or above `RISE_TH` flags it good on the next clock edge. Any code below `RISE_TH` leaves it bad.
- R3: With the supply flagged good, it stays good for any code at or above `RISE_TH - HYST`, so chatter inside that band changes nothing. A code below `RISE_TH - HYST` flags it bad on the next edge.
- R4: A bad supply forces `scan_mode` to lockout on the same edge that flags it bad, from any mode and whatever `enable` is. It also discards any delay progress, so a later start-up runs the full delay again.
- R5: With the supply good and `enable` low, `scan_mode` is 1 (forced-low).
- R6: Suppose the supply is already good and `enable` is first sampled high on edge E. Then `scan_mode` stays 1 through edge E+D and becomes 2 on edge E+D+1, where D is `delay_cycles`. D is held steady during a start-up.
- R7: Suppose `enable` is already high while the supply is bad. Then the delay starts on the edge E that flags the supply good, and `scan_mode` becomes 2 on edge E+D+1.
- R8: With D = 0, `scan_mode` becomes 2 on the edge right after the start edge.
- R9: `enable` sampled low while the supply is good gives `scan_mode` 1 on that same edge, whether the block was waiting out the delay or running. Raising `enable` again restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | CODE_W | Digitised high-supply level |
| enable | input | 1 | Start request from the system |
| delay_cycles | input | DLY_W | Start-up delay in clock cycles (0 means none) |
| scan_mode | output | 2 | 0 lockout, 1 forced-low, 2 run |

## Verification
Every input reaches `scan_mode` through a single register stage. The bench therefore drives on the falling edge and compares on the next falling edge, after exactly one rising edge. Start-up timing is swept over delays 0 to 5: for each delay the mode is compared after every edge from the first to D+3 past the start edge, and is expected to be 2 from edge D+1 onward. The same per-edge count is used after a supply-first start, after enable is dropped mid-delay, and after the supply fails during a delay or during run. Threshold behaviour is swept code by code on both sides of the hysteresis band.

// File: rtl/rail_startup_seq.sv
module rail_startup_seq #(
  parameter int CODE_W  = 8,
  parameter int RISE_TH = 100,
  parameter int HYST    = 8,
  parameter int DLY_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] supply_code,
  input  logic              enable,
  input  logic [DLY_W-1:0]  delay_cycles,
  output logic [1:0]        scan_mode
);
  localparam logic [CODE_W-1:0] RISE_C = CODE_W'(RISE_TH);
  localparam logic [CODE_W-1:0] FALL_C = CODE_W'(RISE_TH - HYST);

  typedef enum logic [1:0] {S_LOCK, S_OFF, S_DLY, S_RUN} st_t;

  st_t              state;
  logic [DLY_W-1:0] cnt;
  logic             supply_ok;

  wire ok_nx = supply_ok ? (supply_code >= FALL_C) : (supply_code >= RISE_C);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) supply_ok <= 1'b0;
    else        supply_ok <= ok_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LOCK;
      cnt   <= '0;
    end else if (!ok_nx) begin
      state <= S_LOCK;
      cnt   <= '0;
    end else begin
      case (state)
        S_LOCK, S_OFF: begin
          cnt   <= '0;
          state <= enable ? S_DLY : S_OFF;
        end
        S_DLY:
          if (!enable) begin
            state <= S_OFF;
            cnt   <= '0;
          end else if (cnt >= delay_cycles) begin
            state <= S_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default:
          if (!enable) state <= S_OFF;
      endcase
    end
  end

  assign scan_mode = (state == S_LOCK) ? 2'd0 :
                     (state == S_RUN)  ? 2'd2 : 2'd1;

  // R4
  lock_when_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> scan_mode == 2'd0);

  // R2
  rise_above_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |-> $past(supply_code) >= RISE_C);

  // R3
  fall_below_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_ok) |-> $past(supply_code) < FALL_C);

  // R9
  no_run_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scan_mode != 2'd2);

  // R6
  run_via_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && $past(state) != S_RUN) |-> $past(state) == S_DLY);

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode != 2'd3);
endmodule

// File: tb/test_rail_startup_seq.sv
module test_rail_startup_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  code;
  logic        en;
  logic [11:0] dly;
  logic [1:0]  mode;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rail_startup_seq #(.CODE_W(8), .RISE_TH(100), .HYST(8), .DLY_W(12)) i_rail_startup_seq (
    .clk(clk), .rst_n(rst_n), .supply_code(code), .enable(en),
    .delay_cycles(dly), .scan_mode(mode));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic [1:0] exp, input string tag);
    checks++;
    if (mode !== exp) begin
      fails++;
      $display("FAIL %s: scan_mode=%0d expected %0d at %0t", tag, mode, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // start already issued; expect run from edge d+2 after the inputs change
  task automatic walk(input int d, input int first_k, input string tag);
    for (int k = first_k; k <= d + 3; k++) begin
      step();
      chk((k >= d + 2) ? 2'd2 : 2'd1, tag);
    end
  endtask

  initial begin
    #(20 * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; code = '0; en = 1'b0; dly = '0;
    repeat (3) step();
    chk(2'd0, "R1");
    rst_n = 1'b1;
    step(); chk(2'd0, "R1");

    // R2 rising sweep
    for (int v = 90; v <= 100; v++) begin
      code = 8'(v); step();
      chk((v >= 100) ? 2'd1 : 2'd0, "R2");
    end
    // R3 falling sweep through the band
    for (int v = 99; v >= 91; v--) begin
      code = 8'(v); step();
      chk((v >= 92) ? 2'd1 : 2'd0, "R3");
    end
    // R3 chatter below the rising threshold stays in lockout
    code = 8'd99; step(); chk(2'd0, "R3");
    code = 8'd95; step(); chk(2'd0, "R3");
    code = 8'd100; step(); chk(2'd1, "R5");
    code = 8'd92; step(); chk(2'd1, "R3");
    code = 8'd97; step(); chk(2'd1, "R3");

    // R6 / R8 enable after supply, delay sweep
    code = 8'd120;
    for (int d = 0; d <= 5; d++) begin
      en = 1'b0; dly = 12'(d); step(); chk(2'd1, "R5");
      en = 1'b1;
      walk(d, 1, (d == 0) ? "R8" : "R6");
      en = 1'b0; step(); chk(2'd1, "R9");
    end

    // R7 enable first, then supply
    code = 8'd50; step(); chk(2'd0, "R4");
    en = 1'b1; step(); chk(2'd0, "R4");
    dly = 12'd3; code = 8'd120;
    walk(3, 1, "R7");

    // R9 drop during delay, then full restart
    dly = 12'd4; en = 1'b0; step(); chk(2'd1, "R9");
    en = 1'b1; step(); chk(2'd1, "R9"); step(); chk(2'd1, "R9");
    en = 1'b0; step(); chk(2'd1, "R9");
    en = 1'b1;
    walk(4, 1, "R9");

    // R4 supply failure in run, then restart with enable held
    code = 8'd91; step(); chk(2'd0, "R4");
    code = 8'd120;
    walk(4, 1, "R4");

    // R4 supply failure mid-delay clears progress
    code = 8'd80; step(); chk(2'd0, "R4");
    code = 8'd120; step(); chk(2'd1, "R4"); step(); chk(2'd1, "R4");
    code = 8'd85; step(); chk(2'd0, "R4");
    code = 8'd100;
    walk(4, 1, "R4");

    // R8 zero delay from supply-first start
    en = 1'b0; dly = '0; step(); chk(2'd1, "R5");
    en = 1'b1; step(); chk(2'd1, "R8"); step(); chk(2'd2, "R8");

    finish_run();
  end
endmodule